// File: doc/BRIEF.md
# Delay-Slot Program Counter

This block holds the instruction fetch address of a small 16-bit processor whose pipeline has two stages, fetch and decode. On each cycle in which fetch is enabled, the instruction at `fetch_addr` is fetched. At the same clock edge the block moves to the next address. In sequential flow the next address is the current one plus one.

The decode stage passes in the control-op code of the instruction it currently holds. It also passes that instruction's register operand, its 8-bit immediate and the value of the general register under test. A taken control op loads a new address at the end of the decode cycle. The instruction fetched during that cycle is the delay-slot instruction, and it always executes.

`fetch_addr` already points one past the instruction in decode. Software therefore performs a relative jump by reading this value, adding an offset, and moving the result back into the counter.

All pins are plain control and status signals with no valid/ready handshake. `fetch_en` is the only flow control. While it is low, the counter and the delay-slot marker hold their values and the decoded op has no effect.

Top module: `delay_branch_pcu`

## Requirements
- R1: When `rst` is sampled high at a rising edge, `fetch_addr` becomes 0x0000 and `delay_slot` becomes 0 after that edge. This holds whatever the other inputs are.
- R2: At an edge with `fetch_en` high and no taken control op, `fetch_addr` increases by one, wrapping from 0xFFFF to 0x0000.
- R3: At an edge with `fetch_en` low, `fetch_addr` and `delay_slot` keep their values and `ctl_op` has no effect.
- R4: `ctl_op` = 3'b001 loads the full 16-bit `reg_val` into the counter unconditionally.
- R5: Conditional forms are taken only as follows. Codes 3'b010 and 3'b110 are taken only when `test_val` equals 0x0000. Codes 3'b011 and 3'b111 are taken only when `test_val` differs from 0x0000. When not taken, the counter increments as in R2.
- R6: Codes 3'b101, 3'b110 and 3'b111 take their target from `imm`, zero-extended to 16 bits. Code 3'b101 is unconditional. Register-sourced forms take their target from `reg_val`.
- R7: A control op presented in cycle t does not change `fetch_addr` during cycle t. When taken, its target appears as `fetch_addr` in cycle t+1, so the address fetched in cycle t executes as the delay slot.
- R8: `delay_slot` is 1 exactly in the cycles that follow an enabled edge at which a control op was taken, and 0 otherwise.
- R9: A control op decoded in a delay slot is evaluated normally. If taken, its target follows the first target by exactly one cycle.
- R10: Codes 3'b000 and 3'b100 are not control ops; they leave the counter incrementing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | High when a fetch happens this cycle; low stalls the counter |
| ctl_op | input | 3 | Decoded control op: bit 2 selects the immediate source, bits 1:0 give the condition (00 none, 01 always, 10 zero, 11 non-zero) |
| reg_val | input | 16 | Register operand, used as the target by register-sourced ops |
| imm | input | 8 | Immediate target for immediate-sourced ops |
| test_val | input | 16 | Value of the tested general register |
| fetch_addr | output | 16 | Address of the instruction being fetched |
| delay_slot | output | 1 | High while the instruction fetched last cycle is a delay-slot instruction |

## Verification
A corrupted counter shows up on `fetch_addr` in the very next cycle, because the counter drives that port directly. After that the error persists: every later address is offset until a taken load overwrites it. A wrong taken decision shows up one cycle after the control op as either a missing jump or a spurious jump. It also shows up in the same cycle on `delay_slot`. The bench compares both outputs against a behavioural model after every edge, and also checks a moment after each new op is applied that `fetch_addr` has not moved before the edge.

// File: rtl/dbpcu_pkg.sv
package dbpcu_pkg;

  // Condition field of a control op (bits 1:0)
  typedef enum logic [1:0] {
    COND_NONE    = 2'b00,
    COND_ALWAYS  = 2'b01,
    COND_ZERO    = 2'b10,
    COND_NONZERO = 2'b11
  } cond_e;

  // Control op: bit 2 picks the immediate as target source
  typedef struct packed {
    logic  use_imm;
    cond_e cond;
  } ctl_op_t;

  localparam int unsigned CTL_OP_W = $bits(ctl_op_t);

endpackage

// File: rtl/dbpcu_decide.sv
module dbpcu_decide
  import dbpcu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  ctl_op_t           op,
  input  logic [DATA_W-1:0] test_val,
  output logic              take,
  output logic              use_imm
);

  logic is_zero;

  assign is_zero = ~|test_val;
  assign use_imm = op.use_imm;

  always_comb begin
    unique case (op.cond)
      COND_ALWAYS:  take = 1'b1;
      COND_ZERO:    take = is_zero;
      COND_NONZERO: take = ~is_zero;
      default:      take = 1'b0;
    endcase
  end

  // R10: no condition field means never taken
  always_comb begin
    if (op.cond == COND_NONE) begin
      p_none_never_taken_r10: assert (!take || $isunknown(op));
    end
  end

endmodule

// File: rtl/dbpcu_target.sv
module dbpcu_target #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IMM_W  = 8
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [ADDR_W-1:0] target
);

  logic [ADDR_W-1:0] reg_tgt;
  logic [ADDR_W-1:0] imm_tgt;

  generate
    if (DATA_W >= ADDR_W) begin : g_reg_trunc
      assign reg_tgt = reg_val[ADDR_W-1:0];
    end else begin : g_reg_ext
      assign reg_tgt = {{(ADDR_W-DATA_W){1'b0}}, reg_val};
    end

    if (IMM_W >= ADDR_W) begin : g_imm_trunc
      assign imm_tgt = imm[ADDR_W-1:0];
    end else begin : g_imm_ext
      // R6: immediate targets are zero-extended
      assign imm_tgt = {{(ADDR_W-IMM_W){1'b0}}, imm};
    end
  endgenerate

  assign target = use_imm ? imm_tgt : reg_tgt;

endmodule

// File: rtl/dbpcu_seq.sv
module dbpcu_seq #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              take,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc,
  output logic              slot
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] pc_nxt;
  logic              slot_q;

  assign pc_inc = pc_q + ADDR_W'(1);
  assign pc_nxt = take ? target : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_ADDR;
      slot_q <= 1'b0;
    end else if (adv) begin
      pc_q   <= pc_nxt;
      slot_q <= take;
    end
  end

  assign pc   = pc_q;
  assign slot = slot_q;

  // R1: reset vector and cleared marker
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc == RESET_ADDR) && !slot);

  // R2: sequential advance with wrap
  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !take) |=> pc == $past(pc) + ADDR_W'(1));

  // R3: stall freezes all state
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc) && $stable(slot));

  // R7: taken target lands exactly one edge later
  p_target_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && take) |=> pc == $past(target));

  // R8: marker follows a taken op
  p_slot_marks_r8: assert property (@(posedge clk) disable iff (rst)
    adv |=> slot == $past(take));

endmodule

// File: rtl/delay_branch_pcu.sv
module delay_branch_pcu
  import dbpcu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic [2:0]        ctl_op,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] test_val,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              delay_slot
);

  localparam logic [ADDR_W-1:0] RESET_ADDR = '0;

  ctl_op_t           op;
  logic              take;
  logic              use_imm;
  logic [ADDR_W-1:0] target;

  assign op = ctl_op_t'(ctl_op);

  dbpcu_decide #(.DATA_W(DATA_W)) u_decide (
    .op       (op),
    .test_val (test_val),
    .take     (take),
    .use_imm  (use_imm)
  );

  dbpcu_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) u_target (
    .reg_val (reg_val),
    .imm     (imm),
    .use_imm (use_imm),
    .target  (target)
  );

  dbpcu_seq #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .adv    (fetch_en),
    .take   (take),
    .target (target),
    .pc     (fetch_addr),
    .slot   (delay_slot)
  );

  // R5: zero-test op with non-zero register falls through
  p_zero_fails_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && ctl_op[1:0] == 2'b10 && test_val != '0)
      |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  // R5: non-zero-test op with zero register falls through
  p_nonzero_fails_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && ctl_op[1:0] == 2'b11 && test_val == '0)
      |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  // R6: a taken immediate form lands within the immediate range
  p_imm_range_r6: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && ctl_op == 3'b101)
      |=> (fetch_addr >> IMM_W) == '0);

  // R4: unconditional register form lands on the operand
  p_reg_load_r4: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && ctl_op == 3'b001)
      |=> fetch_addr == $past(reg_val[ADDR_W-1:0]));

endmodule

// File: tb/delay_branch_pcu_bench.sv
module delay_branch_pcu_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic [2:0]  ctl_op = 3'b000;
  logic [15:0] reg_val = '0;
  logic [7:0]  imm = '0;
  logic [15:0] test_val = '0;
  logic [15:0] fetch_addr;
  logic        delay_slot;

  delay_branch_pcu u_delay_branch_pcu (
    .clk        (clk),
    .rst        (rst),
    .fetch_en   (fetch_en),
    .ctl_op     (ctl_op),
    .reg_val    (reg_val),
    .imm        (imm),
    .test_val   (test_val),
    .fetch_addr (fetch_addr),
    .delay_slot (delay_slot)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    finished = 1'b0;
  int    m_pc = 0;
  bit    m_slot = 1'b0;
  string m_tag = "R1";

  function automatic bit m_take(input logic [2:0] op, input logic [15:0] tv);
    case (op)
      3'd1, 3'd5: return 1'b1;
      3'd2, 3'd6: return tv == 16'h0000;
      3'd3, 3'd7: return tv != 16'h0000;
      default:    return 1'b0;
    endcase
  endfunction

  // Behavioural reference: advances at each rising edge
  always @(posedge clk) begin
    bit t;
    int tgt;
    if (rst) begin
      m_pc = 0; m_slot = 0; m_tag = "R1";
    end else if (!fetch_en) begin
      m_tag = "R3";
    end else begin
      t   = m_take(ctl_op, test_val);
      tgt = ctl_op[2] ? int'(imm) : int'(reg_val);
      if (t && m_slot)            m_tag = "R9";
      else if (ctl_op == 3'd4)    m_tag = "R10";
      else if (ctl_op == 3'd0)    m_tag = "R2";
      else if (ctl_op == 3'd1)    m_tag = "R4";
      else if (ctl_op == 3'd5)    m_tag = "R6";
      else                        m_tag = "R5";
      m_pc   = t ? tgt : ((m_pc + 1) & 16'hFFFF);
      m_slot = t;
    end
  end

  task automatic compare();
    vectors++;
    if (fetch_addr !== m_pc[15:0]) begin
      fails++;
      $display("FAIL %s fetch_addr actual=%h expected=%h", m_tag, fetch_addr, m_pc[15:0]);
    end
    vectors++;
    if (delay_slot !== m_slot) begin
      fails++;
      $display("FAIL R8 delay_slot actual=%b expected=%b", delay_slot, m_slot);
    end
  endtask

  task automatic step(input logic r, input logic fe, input logic [2:0] op,
                      input logic [15:0] rv, input logic [7:0] im, input logic [15:0] tv);
    @(negedge clk);
    compare();
    rst = r; fetch_en = fe; ctl_op = op; reg_val = rv; imm = im; test_val = tv;
    #1;
    // R7: a new op must not move the address before the edge
    vectors++;
    if (fetch_addr !== m_pc[15:0]) begin
      fails++;
      $display("FAIL R7 early change actual=%h expected=%h", fetch_addr, m_pc[15:0]);
    end
  endtask

  initial begin
    // R1: reset state
    step(1, 1, 3'd1, 16'h5555, 8'h11, 16'h0);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    // R2: plain sequential run
    for (int i = 0; i < 12; i++) step(0, 1, 3'd0, 16'hBEEF, 8'hAA, 16'h0);
    // R4 then wrap (R2)
    step(0, 1, 3'd1, 16'hFFFD, 8'h00, 16'h1);
    for (int i = 0; i < 6; i++) step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    // R6: immediate with high register bits set
    step(0, 1, 3'd5, 16'hFFFF, 8'hA7, 16'h3);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    // R5: each conditional form, taken and not
    step(0, 1, 3'd2, 16'h0300, 8'h0, 16'h0000);
    step(0, 1, 3'd2, 16'h0400, 8'h0, 16'h0005);
    step(0, 1, 3'd3, 16'h0500, 8'h0, 16'h0000);
    step(0, 1, 3'd3, 16'h0600, 8'h0, 16'h8000);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    step(0, 1, 3'd6, 16'h0, 8'h33, 16'h0000);
    step(0, 1, 3'd6, 16'h0, 8'h44, 16'h0001);
    step(0, 1, 3'd7, 16'h0, 8'h55, 16'h0000);
    step(0, 1, 3'd7, 16'h0, 8'h66, 16'hFFFF);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    // R9: control op in the delay slot
    step(0, 1, 3'd1, 16'h1234, 8'h0, 16'h0);
    step(0, 1, 3'd5, 16'h0, 8'h40, 16'h0);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    // R3: stall with a taken op present
    step(0, 1, 3'd1, 16'h2000, 8'h0, 16'h0);
    for (int i = 0; i < 5; i++) step(0, 0, 3'd1, 16'h7777, 8'h0, 16'h0);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    for (int i = 0; i < 4; i++) step(0, 0, 3'd5, 16'h0, 8'h99, 16'h0);
    // R10: non-control codes
    step(0, 1, 3'd4, 16'hAAAA, 8'hBB, 16'h0);
    step(0, 1, 3'd0, 16'hCCCC, 8'hDD, 16'h0);
    step(0, 1, 3'd4, 16'h1111, 8'h22, 16'h0);
    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] tv;
      tv = ($urandom_range(0, 1) == 0) ? 16'h0 : 16'($urandom);
      step(($urandom_range(0, 199) == 0), ($urandom_range(0, 4) != 0),
           3'($urandom), 16'($urandom), 8'($urandom), tv);
    end
    // R1: reset mid-run with a taken op present
    step(1, 1, 3'd1, 16'h4321, 8'h0, 16'h0);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    step(0, 1, 3'd0, 16'h0, 8'h0, 16'h0);
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule